// File: doc/BRIEF.md
# Asynchronous External Bus Master Sequencer

This block turns single requests from an internal valid/ready port into complete read or write cycles on an asynchronous parallel bus for one chip-select region. Every cycle has three phases. During lead, the select is low and both strobes are high. During active, the read or write strobe is low. During trail, the strobes are high again and the select is still held low. The length of each phase is counted in timing-clock ticks. The timing clock runs at half the system clock, so one tick equals two system clocks. Reads and writes each have their own lead, active and trail counts. A global doubling control multiplies the length of every phase by two.

An optional ready input from the far side can hold the active phase open. This input passes through a two-stage synchronizer when asynchronous mode is selected, and through a single register otherwise. A 2-bit width code selects a 16-bit or 32-bit data path. Requests are refused while the code holds a reserved value. When a cycle completes, a one-cycle response pulse returns the read data. That data is captured at the moment the active phase ends. The block also drives a bus clock at one quarter of the system clock. The data bus is split into output, output-enable and input ports, to be joined in the pad ring.

Top module: `extbus_master`

## Requirements
- R1: After reset, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, and `bus_doe`, `rsp_valid` and `bus_clk` are low.
- R2: A write holds `bus_cs_n` low for the lead phase of 2*max(wr_lead,1) system clocks with both strobes high. It then holds `bus_wr_n` low for 2*wr_active clocks. It then holds both strobes high for 2*wr_trail clocks before `bus_cs_n` rises.
- R3: A read uses the separate read counts and drives `bus_rd_n` low in active instead of `bus_wr_n`. The two strobes are never low together, and neither is low while `bus_cs_n` is high.
- R4: When `cfg_double` is 1, each phase lasts twice its programmed number of ticks.
- R5: A lead count of 0 is treated as 1.
- R6: `bus_doe` is high only during the active and trail phases of a write. While it is high, `bus_dout` holds the write data and does not change. During the lead phase, reads and idle, `bus_doe` stays low.
- R7: When `cfg_use_ready` is 1, the active phase ends only after its count has elapsed and `bus_ready` is seen high. The strobe rises within 6 clocks of `bus_ready` rising. With ready in use, an active count of 0 is treated as 1. When `cfg_use_ready` is 0, `bus_ready` has no effect on timing.
- R8: `rsp_valid` pulses for exactly one clock, on the clock after `bus_cs_n` rises. On a read, `rsp_rdata` carries the `bus_din` value sampled at the end of active.
- R9: `cfg_size` 2'b11 selects 16 bits: only bits 15:0 of the write data are driven, read data bits 31:16 return 0, and `bus_dout` bits 31:16 are 0. `cfg_size` 2'b01 selects the full 32 bits. Any other value holds `req_ready` low, so no cycle starts.
- R10: `req_ready` is high only while no cycle is in progress. A request is taken on a clock where `req_valid` and `req_ready` are both high.
- R11: When `cfg_busclk_en` is 1, `bus_clk` toggles every 2 system clocks. When it is 0, `bus_clk` is held low.
- R12: A zero active count (ready not in use) or a zero trail count skips that phase. With both zero, a write ends right after lead, and `bus_doe` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_lead | input | 4 | Write lead count, in ticks |
| cfg_wr_active | input | 4 | Write active count, in ticks |
| cfg_wr_trail | input | 4 | Write trail count, in ticks |
| cfg_rd_lead | input | 4 | Read lead count, in ticks |
| cfg_rd_active | input | 4 | Read active count, in ticks |
| cfg_rd_trail | input | 4 | Read trail count, in ticks |
| cfg_double | input | 1 | Doubles every phase length |
| cfg_use_ready | input | 1 | Lets `bus_ready` extend the active phase |
| cfg_ready_async | input | 1 | 1: two-stage synchronizer on ready; 0: single register |
| cfg_size | input | 2 | Width code: 11 = 16 bit, 01 = 32 bit, others reserved |
| cfg_busclk_en | input | 1 | Enables `bus_clk` |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this clock if `req_valid` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_cs_n | output | 1 | Region select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Data driven toward the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | DATA_W | Data read from the bus |
| bus_ready | input | 1 | Ready from the far side (may be asynchronous) |
| bus_clk | output | 1 | Divided bus clock |

## Verification
A wrong phase counter or a wrong length latched at acceptance changes the number of clocks the select or a strobe stays low. That error appears at the pins within the cycle in which it occurs, so the bench measures every phase to the exact clock. A wrong phase state shows up at once as an output enable during lead or during a read, or as a strobe outside the select window. A lost ready synchronizer stage, or one too many, shifts the rise of the strobe after ready by a clock or more. A wrong capture point shows on `rsp_rdata` at the completion pulse of that same cycle.

// File: rtl/xbus_pkg.sv
// Shared types and helpers for the external bus sequencer.
// Assumes phase counts fit in XB_CNT_W bits; doubled lengths fit in one more bit.
package xbus_pkg;

    parameter int unsigned XB_CNT_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LEAD   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_TRAIL  = 2'd3
    } xb_phase_e;

    localparam logic [1:0] XB_SIZE_16 = 2'b11;
    localparam logic [1:0] XB_SIZE_32 = 2'b01;

    // Effective phase length in ticks: optional floor of one, optional doubling.
    function automatic logic [XB_CNT_W:0] xb_eff_len(
        input logic [XB_CNT_W-1:0] n,
        input logic                dbl,
        input logic                at_least_one
    );
        logic [XB_CNT_W:0] base;
        base = {1'b0, n};
        if (at_least_one && (n == '0)) begin
            base = (XB_CNT_W+1)'(1);
        end
        return dbl ? (base << 1) : base;
    endfunction

endpackage

// File: rtl/xbus_clkgen.sv
// Timing tick and bus clock generator.
// tick_o is high every other system clock (timing clock = sysclk/2).
// busclk_o toggles on every tick when enabled, giving sysclk/4; held low otherwise.
module xbus_clkgen (
    input  logic clk,
    input  logic rst_n,
    input  logic busclk_en,
    output logic tick_o,
    output logic busclk_o
);
    logic tick_q;
    logic bclk_q;

    // Alternate the tick register each system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= ~tick_q;
    end

    // Toggle the bus clock on ticks while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !busclk_en) bclk_q <= 1'b0;
        else if (tick_q)          bclk_q <= ~bclk_q;
    end

    assign tick_o   = tick_q;
    assign busclk_o = bclk_q;
endmodule

// File: rtl/xbus_rdy_sync.sv
// Ready input conditioner.
// A shift chain of STAGES registers; asynchronous mode takes the last stage,
// synchronous mode takes the first. Assumes STAGES >= 2.
module xbus_rdy_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_mode,
    input  logic rdy_i,
    output logic rdy_o
);
    logic [STAGES-1:0] sh_q;

    // Shift the raw ready level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], rdy_i};
    end

    assign rdy_o = async_mode ? sh_q[STAGES-1] : sh_q[0];
endmodule

// File: rtl/xbus_sequencer.sv
// Lead/active/trail phase sequencer.
// Latches the phase lengths when start_i is high (start only while idle, on a tick).
// Phases advance only on tick edges; zero-length active/trail phases are skipped.
// cap_o marks the edge where active ends (or lead ends with active skipped).
module xbus_sequencer
    import xbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                start_i,
    input  logic [XB_CNT_W-1:0] lead_i,
    input  logic [XB_CNT_W-1:0] act_i,
    input  logic [XB_CNT_W-1:0] trail_i,
    input  logic                dbl_i,
    input  logic                use_rdy_i,
    input  logic                rdy_s_i,
    output xb_phase_e           phase_o,
    output logic                cap_o,
    output logic                done_o
);
    localparam int unsigned LW = XB_CNT_W + 1;

    xb_phase_e     phase_q;
    xb_phase_e     next_ph;
    logic [LW-1:0] lead_len_q, act_len_q, trail_len_q;
    logic [LW-1:0] cnt_q, cur_len, last_idx;
    logic          use_rdy_q;
    logic          phase_end;
    logic          done_q;

    // Length of the phase currently running.
    always_comb begin
        case (phase_q)
            PH_LEAD:   cur_len = lead_len_q;
            PH_ACTIVE: cur_len = act_len_q;
            PH_TRAIL:  cur_len = trail_len_q;
            default:   cur_len = '0;
        endcase
    end

    assign last_idx = cur_len - LW'(1);

    // Decide whether the current phase finishes on this tick.
    always_comb begin
        case (phase_q)
            PH_LEAD:   phase_end = (cnt_q == last_idx);
            PH_ACTIVE: phase_end = (cnt_q >= last_idx) && (!use_rdy_q || rdy_s_i);
            PH_TRAIL:  phase_end = (cnt_q == last_idx);
            default:   phase_end = 1'b0;
        endcase
    end

    // Pick the following phase, skipping empty ones.
    always_comb begin
        case (phase_q)
            PH_LEAD:   next_ph = (act_len_q != '0) ? PH_ACTIVE :
                                 (trail_len_q != '0) ? PH_TRAIL : PH_IDLE;
            PH_ACTIVE: next_ph = (trail_len_q != '0) ? PH_TRAIL : PH_IDLE;
            default:   next_ph = PH_IDLE;
        endcase
    end

    // Phase register, tick counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            lead_len_q  <= '0;
            act_len_q   <= '0;
            trail_len_q <= '0;
            use_rdy_q   <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                phase_q     <= PH_LEAD;
                cnt_q       <= '0;
                lead_len_q  <= xb_eff_len(lead_i, dbl_i, 1'b1);
                act_len_q   <= xb_eff_len(act_i, dbl_i, use_rdy_i);
                trail_len_q <= xb_eff_len(trail_i, dbl_i, 1'b0);
                use_rdy_q   <= use_rdy_i;
            end else if (tick_i && (phase_q != PH_IDLE)) begin
                if (phase_end) begin
                    phase_q <= next_ph;
                    cnt_q   <= '0;
                    done_q  <= (next_ph == PH_IDLE);
                end else if (cnt_q < last_idx) begin
                    cnt_q <= cnt_q + LW'(1);
                end
            end
        end
    end

    assign cap_o   = tick_i && phase_end &&
                     ((phase_q == PH_ACTIVE) ||
                      ((phase_q == PH_LEAD) && (next_ph != PH_ACTIVE)));
    assign phase_o = phase_q;
    assign done_o  = done_q;
endmodule

// File: rtl/extbus_master.sv
// External asynchronous bus master for one select region.
// Accepts one request at a time from a valid/ready port, runs a lead/active/trail
// cycle, then returns a one-clock response. Configuration inputs are assumed
// static while a cycle is in progress. The data bus is split; the pad ring joins it.
module extbus_master
    import xbus_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned RDY_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XB_CNT_W-1:0] cfg_wr_lead,
    input  logic [XB_CNT_W-1:0] cfg_wr_active,
    input  logic [XB_CNT_W-1:0] cfg_wr_trail,
    input  logic [XB_CNT_W-1:0] cfg_rd_lead,
    input  logic [XB_CNT_W-1:0] cfg_rd_active,
    input  logic [XB_CNT_W-1:0] cfg_rd_trail,
    input  logic                cfg_double,
    input  logic                cfg_use_ready,
    input  logic                cfg_ready_async,
    input  logic [1:0]          cfg_size,
    input  logic                cfg_busclk_en,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                bus_cs_n,
    output logic                bus_rd_n,
    output logic                bus_wr_n,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_doe,
    input  logic [DATA_W-1:0]   bus_din,
    input  logic                bus_ready,
    output logic                bus_clk
);
    localparam int unsigned NARROW_W = DATA_W / 2;

    logic        tick;
    logic        rdy_s;
    logic        accept;
    logic        size_ok;
    logic        cap;
    logic        done;
    xb_phase_e   phase;

    logic                we_q;
    logic                wide_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic [DATA_W-1:0]   wdata_fit;
    logic [DATA_W-1:0]   din_fit;

    xbus_clkgen u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .busclk_en (cfg_busclk_en),
        .tick_o    (tick),
        .busclk_o  (bus_clk)
    );

    xbus_rdy_sync #(.STAGES(RDY_STAGES)) u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_mode (cfg_ready_async),
        .rdy_i      (bus_ready),
        .rdy_o      (rdy_s)
    );

    xbus_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .start_i   (accept),
        .lead_i    (req_write ? cfg_wr_lead   : cfg_rd_lead),
        .act_i     (req_write ? cfg_wr_active : cfg_rd_active),
        .trail_i   (req_write ? cfg_wr_trail  : cfg_rd_trail),
        .dbl_i     (cfg_double),
        .use_rdy_i (cfg_use_ready),
        .rdy_s_i   (rdy_s),
        .phase_o   (phase),
        .cap_o     (cap),
        .done_o    (done)
    );

    assign size_ok   = (cfg_size == XB_SIZE_16) || (cfg_size == XB_SIZE_32);
    assign req_ready = (phase == PH_IDLE) && tick && size_ok;
    assign accept    = req_valid && req_ready;

    // Width fitting: narrow mode keeps only the low half of each data word.
    always_comb begin
        if (cfg_size == XB_SIZE_32) wdata_fit = req_wdata;
        else                        wdata_fit = {{(DATA_W-NARROW_W){1'b0}}, req_wdata[NARROW_W-1:0]};
        if (wide_q) din_fit = bus_din;
        else        din_fit = {{(DATA_W-NARROW_W){1'b0}}, bus_din[NARROW_W-1:0]};
    end

    // Hold request fields for the whole bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            wide_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= req_write;
            wide_q  <= (cfg_size == XB_SIZE_32);
            addr_q  <= req_addr;
            wdata_q <= wdata_fit;
        end
    end

    // Capture read data where the active phase ends.
    always_ff @(posedge clk) begin
        if (!rst_n)            rdata_q <= '0;
        else if (cap && !we_q) rdata_q <= din_fit;
    end

    assign bus_cs_n  = (phase == PH_IDLE);
    assign bus_rd_n  = !((phase == PH_ACTIVE) && !we_q);
    assign bus_wr_n  = !((phase == PH_ACTIVE) && we_q);
    assign bus_doe   = we_q && ((phase == PH_ACTIVE) || (phase == PH_TRAIL));
    assign bus_dout  = wdata_q;
    assign bus_addr  = addr_q;
    assign rsp_valid = done;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/extbus_master_chk.sv
// Protocol checker for extbus_master, attached by bind below.
// Relates the port-level strobes, select, enable and handshake over time.
module extbus_master_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_doe,
    input logic [DATA_W-1:0] bus_dout,
    input logic [1:0]        cfg_size,
    input logic              cfg_busclk_en,
    input logic              bus_clk
);
    // R3: strobes only inside the select window.
    a_r3_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

    // R3: never both strobes at once.
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // R6: output enable only within a selected, non-read cycle.
    a_r6_oe_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (!bus_cs_n && bus_rd_n));

    // R6: driven data stays put while enabled.
    a_r6_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe)) |-> $stable(bus_dout));

    // R8: completion lasts one clock.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R10: no acceptance while a cycle holds the select.
    a_r10_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> bus_cs_n);

    // R9: reserved width codes refuse requests.
    a_r9_reserved_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_size != 2'b11) && (cfg_size != 2'b01)) |-> !req_ready);

    // R11: disabled bus clock goes and stays low.
    a_r11_busclk_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_busclk_en |=> !bus_clk);
endmodule

bind extbus_master extbus_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .bus_cs_n      (bus_cs_n),
    .bus_rd_n      (bus_rd_n),
    .bus_wr_n      (bus_wr_n),
    .bus_doe       (bus_doe),
    .bus_dout      (bus_dout),
    .cfg_size      (cfg_size),
    .cfg_busclk_en (cfg_busclk_en),
    .bus_clk       (bus_clk)
);

// File: tb/extbus_master_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module extbus_master_tb_top;
    localparam int AW = 20;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3:0] wr_lead = 4'd3, wr_act = 4'd7, wr_trail = 4'd3;
    logic [3:0] rd_lead = 4'd3, rd_act = 4'd7, rd_trail = 4'd3;
    logic dbl = 1'b0, use_rdy = 1'b0, rdy_async = 1'b1, bclk_en = 1'b0;
    logic [1:0] size = 2'b11;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] bus_din = '0;
    logic bus_ready = 1'b1;
    logic req_ready, rsp_valid, bus_cs_n, bus_rd_n, bus_wr_n, bus_doe, bus_clk;
    logic [DW-1:0] rsp_rdata, bus_dout;
    logic [AW-1:0] bus_addr;

    extbus_master #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_lead(wr_lead), .cfg_wr_active(wr_act), .cfg_wr_trail(wr_trail),
        .cfg_rd_lead(rd_lead), .cfg_rd_active(rd_act), .cfg_rd_trail(rd_trail),
        .cfg_double(dbl), .cfg_use_ready(use_rdy), .cfg_ready_async(rdy_async),
        .cfg_size(size), .cfg_busclk_en(bclk_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_ready(bus_ready), .bus_clk(bus_clk)
    );

    int n_checks = 0;
    int n_fail = 0;

    // Measurements filled by do_access.
    int m_lead, m_act, m_trail, m_oe_bad, m_data_bad, m_strobe_bad, m_busy_bad, m_lat;
    int m_addr_bad;
    bit m_done, m_done_wide;
    logic [DW-1:0] m_rdata;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input longint act, input longint exp);
        check(act == exp, req, act, exp);
    endtask

    // Issue one request and measure the resulting bus cycle at negedges.
    task automatic do_access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             input logic [DW-1:0] exp_dout, input int rel);
        bit seen;
        bit strobe;
        bit exp_oe;
        int w;
        m_lead = 0; m_act = 0; m_trail = 0; m_oe_bad = 0; m_data_bad = 0;
        m_strobe_bad = 0; m_busy_bad = 0; m_lat = -1; m_done = 0; m_done_wide = 0;
        m_addr_bad = 0; m_rdata = '0; seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
        w = 0;
        while (!req_ready && w < 100) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = '1;
        for (int i = 0; i < 3000; i++) begin
            if (rel >= 0 && i == rel) bus_ready = 1'b1;
            if (rsp_valid) begin
                m_rdata = rsp_rdata;
                m_done = 1;
                break;
            end
            if (req_ready) m_busy_bad++;
            strobe = !bus_wr_n || !bus_rd_n;
            if (!bus_cs_n) begin
                if (bus_addr != a) m_addr_bad++;
                if (strobe) begin
                    m_act++;
                    seen = 1;
                end else if (!seen) m_lead++;
                else begin
                    m_trail++;
                    if (m_lat < 0 && rel >= 0) m_lat = i - rel;
                end
            end
            exp_oe = we && !bus_cs_n && seen;
            if (bus_doe !== exp_oe) m_oe_bad++;
            if (bus_doe && bus_dout !== exp_dout) m_data_bad++;
            if ((we && !bus_rd_n) || (!we && !bus_wr_n)) m_strobe_bad++;
            @(negedge clk);
        end
        @(negedge clk);
        m_done_wide = rsp_valid;
    endtask

    task automatic common_checks(input string tag);
        check_eq({tag, " R8 done seen"}, m_done, 1);
        check_eq({tag, " R8 done one clock"}, m_done_wide, 0);
        check_eq({tag, " R6 oe window"}, m_oe_bad, 0);
        check_eq({tag, " R6 dout value"}, m_data_bad, 0);
        check_eq({tag, " R3 strobe kind"}, m_strobe_bad, 0);
        check_eq({tag, " R10 busy refuse"}, m_busy_bad, 0);
        check_eq({tag, " R2 address held"}, m_addr_bad, 0);
    endtask

    task automatic t_reset;
        check_eq("R1 cs_n", bus_cs_n, 1);
        check_eq("R1 rd_n", bus_rd_n, 1);
        check_eq("R1 wr_n", bus_wr_n, 1);
        check_eq("R1 doe", bus_doe, 0);
        check_eq("R1 rsp_valid", rsp_valid, 0);
        check_eq("R1 bus_clk", bus_clk, 0);
    endtask

    task automatic t_write_basic;
        wr_lead = 3; wr_act = 7; wr_trail = 3; dbl = 0; size = 2'b11;
        do_access(1'b1, 20'h04001, 32'hABCD_1234, 32'h0000_1234, -1);
        check_eq("R2 write lead", m_lead, 6);
        check_eq("R2 write active", m_act, 14);
        check_eq("R2 write trail", m_trail, 6);
        common_checks("R2 write");
    endtask

    task automatic t_read_basic;
        rd_lead = 2; rd_act = 4; rd_trail = 1; dbl = 0; size = 2'b11;
        bus_din = 32'hFFFF_5A5A;
        do_access(1'b0, 20'h04002, '0, '0, -1);
        check_eq("R3 read lead", m_lead, 4);
        check_eq("R3 read active", m_act, 8);
        check_eq("R3 read trail", m_trail, 2);
        check_eq("R8 R9 narrow read data", m_rdata, 32'h0000_5A5A);
        common_checks("R3 read");
    endtask

    task automatic t_double;
        wr_lead = 1; wr_act = 2; wr_trail = 1; dbl = 1; size = 2'b11;
        do_access(1'b1, 20'h00010, 32'h0000_00FF, 32'h0000_00FF, -1);
        check_eq("R4 doubled lead", m_lead, 4);
        check_eq("R4 doubled active", m_act, 8);
        check_eq("R4 doubled trail", m_trail, 4);
        common_checks("R4");
        dbl = 0;
    endtask

    task automatic t_lead_zero;
        rd_lead = 0; rd_act = 1; rd_trail = 1; size = 2'b11;
        bus_din = 32'h0000_0009;
        do_access(1'b0, 20'h00020, '0, '0, -1);
        check_eq("R5 lead floor", m_lead, 2);
        check_eq("R5 active", m_act, 2);
        check_eq("R5 read data", m_rdata, 32'h0000_0009);
        common_checks("R5");
    endtask

    task automatic t_wide;
        size = 2'b01;
        wr_lead = 1; wr_act = 1; wr_trail = 1;
        do_access(1'b1, 20'h00030, 32'hDFEE_DBEE, 32'hDFEE_DBEE, -1);
        check_eq("R9 wide write active", m_act, 2);
        common_checks("R9 wide write");
        rd_lead = 1; rd_act = 2; rd_trail = 1;
        bus_din = 32'h1357_9BDF;
        do_access(1'b0, 20'h00031, '0, '0, -1);
        check_eq("R9 wide read data", m_rdata, 32'h1357_9BDF);
        common_checks("R9 wide read");
        size = 2'b11;
    endtask

    task automatic t_reserved;
        int seen_rdy;
        int seen_cs;
        size = 2'b00;
        seen_rdy = 0;
        seen_cs = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (req_ready) seen_rdy++;
            if (!bus_cs_n) seen_cs++;
            @(negedge clk);
        end
        size = 2'b10;
        for (int i = 0; i < 20; i++) begin
            if (req_ready) seen_rdy++;
            if (!bus_cs_n) seen_cs++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check_eq("R9 reserved ready", seen_rdy, 0);
        check_eq("R9 reserved no cycle", seen_cs, 0);
        size = 2'b11;
    endtask

    task automatic t_ready;
        wr_lead = 1; wr_act = 2; wr_trail = 1; size = 2'b11;
        use_rdy = 1; rdy_async = 1;
        bus_ready = 1'b0;
        do_access(1'b1, 20'h00040, 32'h0000_0001, 32'h0000_0001, 30);
        check(m_act > 20, "R7 active held by ready", m_act, 21);
        check(m_lat >= 1 && m_lat <= 6, "R7 ready latency", m_lat, 4);
        common_checks("R7 wait");
        bus_ready = 1'b1;
        wr_act = 0;
        do_access(1'b1, 20'h00041, 32'h0000_0002, 32'h0000_0002, -1);
        check_eq("R7 active floor with ready", m_act, 2);
        use_rdy = 0;
        wr_act = 3;
        bus_ready = 1'b0;
        do_access(1'b1, 20'h00042, 32'h0000_0003, 32'h0000_0003, -1);
        check_eq("R7 ready ignored when off", m_act, 6);
        common_checks("R7 off");
        bus_ready = 1'b1;
    endtask

    task automatic t_skip;
        wr_lead = 2; wr_act = 0; wr_trail = 0; use_rdy = 0;
        do_access(1'b1, 20'h00050, 32'h0000_0004, 32'h0000_0004, -1);
        check_eq("R12 lead only", m_lead, 4);
        check_eq("R12 no active", m_act, 0);
        check_eq("R12 no trail", m_trail, 0);
        common_checks("R12");
    endtask

    task automatic t_busclk;
        int changes;
        logic prev;
        bclk_en = 1;
        repeat (4) @(negedge clk);
        changes = 0;
        prev = bus_clk;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (bus_clk != prev) changes++;
            prev = bus_clk;
        end
        check_eq("R11 bus clock toggles", changes, 8);
        bclk_en = 0;
        @(negedge clk);
        changes = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (bus_clk) changes++;
        end
        check_eq("R11 bus clock off low", changes, 0);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_write_basic();
        t_read_basic();
        t_double();
        t_lead_zero();
        t_wide();
        t_reserved();
        t_ready();
        t_skip();
        t_busclk();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule